// File: doc/BRIEF.md
# Block-Write Transaction Controller

This block is the card-side sequencer for block writes. It takes decoded host commands (single-block write, multi-block write, set-block-count, stop) with their 32-bit arguments. It also takes one event per received data block, marked with the result of that block's CRC check. It decides whether a write may start and tracks whether the card sits in the transfer state or the receive state. For each block that may be stored, it issues one programming request carrying the byte address of that block.

A multi-block write is pre-counted only when a set-block-count command with a non-zero count comes right before it. In every other case it runs open-ended until a stop. A pre-counted write ends by itself after its last block. The top bit of the set-block-count argument asks for a reliable write. That request is granted only when the size and the alignment also qualify. Errors that appear mid-transfer freeze the transfer: later blocks are dropped and the error is reported in the response to the stop command. The physical bus layer and the memory array are outside the block.

Top module: `blkwr_ctl`

## Requirements
- R1: After reset, and after any reset during a transfer, `rcvState` is 0 and `rspValid`, `progReq` and `relMode` are 0.
- R2: A set-block-count (index 23) with non-zero count N, followed at once by a multi-block write (index 25), enters receive (`rcvState`=1). The controller returns to transfer by itself on the cycle that follows the N-th good block. A single-block write (index 24) acts as a pre-counted write with N=1.
- R3: Any other command between the set-block-count and the multi-block write makes the write open-ended. It then stays in receive for any number of blocks, and a stop (index 12) returns it to transfer with `rspErr`=0.
- R4: A set-block-count with count 0 is accepted (`rspErr`=0), and the write that follows is open-ended.
- R5: A stop received in the transfer state, including one after a pre-counted write has completed, responds with `rspErr` bit 4 (illegal command) and leaves the state unchanged. Blocks that arrive in the transfer state are not programmed.
- R6: `relMode` is 1 during a multi-block write when all of these hold: the set-block-count argument has bit 31 set, the block length is 512, the count is 1 or `REL_SECTORS`, and the start address is a multiple of count×512. `relMode` clears when the write ends.
- R7: If any reliable-write condition fails, `relMode` stays 0 and the write runs as a plain pre-counted write.
- R8: A write command whose byte address is at or above `MEM_BYTES` is rejected with `rspErr` bit 0, and the state stays at transfer.
- R9: A write command issued while the block length is 0 or above 512 is rejected with `rspErr` bit 1.
- R10: A write command whose first block would cross a 512-byte boundary is rejected with `rspErr` bit 2.
- R11: While in receive, a block that would cross a 512-byte boundary (bit 2) or run past `MEM_BYTES` (bit 0) is not programmed. Every later block is also ignored, the state stays at receive, and the next stop reports that bit.
- R12: A block with a failed CRC is not programmed, and later blocks are ignored until a stop. The stop reports `rspErr` bit 3.
- R13: Each good block in receive raises `progReq` for one cycle, one clock after the block. `progAddr` equals the start address plus the block length times the number of blocks already programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe: a decoded command is present |
| cmdIdx | input | CMD_W | Command index (12 stop, 23 set count, 24 single write, 25 multi write) |
| cmdArg | input | ARG_W | Command argument (byte address, or count with bit 31 as reliable request) |
| blkLen | input | LEN_W | Current block length in bytes |
| blkValid | input | 1 | One-cycle strobe: a data block has been received |
| blkCrcOk | input | 1 | The CRC of that block matched |
| rcvState | output | 1 | 1 in receive state, 0 in transfer state |
| relMode | output | 1 | Current write runs as a reliable write |
| rspValid | output | 1 | Response to a command, one cycle after it |
| rspErr | output | 5 | Error bits: 0 range, 1 length, 2 misalign, 3 CRC, 4 illegal |
| progReq | output | 1 | Programming request for one block |
| progAddr | output | ARG_W | Byte address for that programming request |

## Verification
The write path is run with a count set directly before the write, with a count separated from the write by another command, with a zero count, and with no count at all. These cases separate auto-termination from open-ended running, and show where a stop is legal or illegal. Reliable requests are applied with a qualifying size at an aligned address, with a qualifying size at a misaligned address, and with a count that does not qualify, so a grant can be told apart from a silent downgrade. Errors are injected at command time (range, length, first-block crossing) and mid-stream (partial blocks drifting across a boundary, the end of memory, a bad CRC). This confirms that command rejections never leave the transfer state and that mid-stream faults suppress all later programming until the stop reports them.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  typedef enum logic {
    ST_TRAN = 1'b0,
    ST_RCV  = 1'b1
  } wr_state_e;

  localparam logic [5:0] CMD_STOP   = 6'd12;
  localparam logic [5:0] CMD_SETCNT = 6'd23;
  localparam logic [5:0] CMD_WR1    = 6'd24;
  localparam logic [5:0] CMD_WRN    = 6'd25;

  localparam int E_RANGE = 0;
  localparam int E_LEN   = 1;
  localparam int E_MIS   = 2;
  localparam int E_CRC   = 3;
  localparam int E_ILL   = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic       ld23;      // capture set-block-count argument
    logic       clr23;     // forget pending count
    logic       start;     // open a transfer
    logic       multi;     // transfer is multi-block
    logic       advance;   // one block accepted
    logic       finish;    // transfer closed
    logic [3:0] latchErr;  // sticky error bits to set
  } strobe_t;

endpackage

// File: rtl/blkwr_dpath.sv
module blkwr_dpath
  import blkwr_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SECT_BYTES  = 512,
  parameter int MEM_BYTES   = 32'h0010_0000,
  parameter int REL_SECTORS = 8,
  parameter bit PARTIAL_OK  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [ARG_W-1:0] cmdArg,
  input  logic [LEN_W-1:0] blkLen,
  output logic             cmdRangeBad,
  output logic             cmdLenBad,
  output logic             cmdMisBad,
  output logic             blkRangeBad,
  output logic             blkMisBad,
  output logic             lastBlk,
  output logic             relMode,
  output logic [3:0]       stickyErr,
  output logic [ARG_W-1:0] curAddr
);

  localparam int OFF_W = $clog2(SECT_BYTES);
  localparam int REL_BYTES = REL_SECTORS * SECT_BYTES;
  localparam logic [LEN_W:0] SECT_L = (LEN_W+1)'(SECT_BYTES);
  localparam logic [ARG_W:0] MEM_L = (ARG_W+1)'(MEM_BYTES);
  localparam logic [ARG_W-1:0] REL_MASK = ARG_W'(REL_BYTES - 1);

  logic [CNT_W-1:0] cnt23;
  logic             rel23Req;
  logic             cmd23Valid;
  logic [CNT_W-1:0] blkCnt;
  logic             counted;
  logic             cnt23Live;
  logic             relOk;
  logic [ARG_W:0]   endAddr;

  function automatic logic crosses(input logic [ARG_W-1:0] a, input logic [LEN_W-1:0] len);
    logic [LEN_W:0] sum;
    sum = (LEN_W+1)'(a[OFF_W-1:0]) + {1'b0, len};
    return sum > SECT_L;
  endfunction

  assign cmdLenBad   = (blkLen == '0) || ({1'b0, blkLen} > SECT_L) ||
                       (!PARTIAL_OK && ({1'b0, blkLen} != SECT_L));
  assign cmdRangeBad = {1'b0, cmdArg} >= MEM_L;
  assign cmdMisBad   = !cmdLenBad && crosses(cmdArg, blkLen);
  assign cnt23Live   = cmd23Valid && (cnt23 != '0);

  assign relOk = rel23Req && ({1'b0, blkLen} == SECT_L) &&
                 (((cnt23 == CNT_W'(1)) && (cmdArg[OFF_W-1:0] == '0)) ||
                  ((cnt23 == CNT_W'(REL_SECTORS)) && ((cmdArg & REL_MASK) == '0)));

  assign endAddr     = {1'b0, curAddr} + (ARG_W+1)'(blkLen);
  assign blkRangeBad = endAddr > MEM_L;
  assign blkMisBad   = crosses(curAddr, blkLen);
  assign lastBlk     = counted && (blkCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt23      <= '0;
      rel23Req   <= 1'b0;
      cmd23Valid <= 1'b0;
      blkCnt     <= '0;
      counted    <= 1'b0;
      relMode    <= 1'b0;
      stickyErr  <= '0;
      curAddr    <= '0;
    end else begin
      if (st.clr23) cmd23Valid <= 1'b0;
      if (st.ld23) begin
        cnt23      <= cmdArg[CNT_W-1:0];
        rel23Req   <= cmdArg[ARG_W-1];
        cmd23Valid <= 1'b1;
      end
      if (st.start) begin
        curAddr   <= cmdArg;
        counted   <= !st.multi || cnt23Live;
        blkCnt    <= st.multi ? cnt23 : CNT_W'(1);
        relMode   <= st.multi && cnt23Live && relOk;
        stickyErr <= '0;
      end
      if (st.advance) begin
        curAddr <= curAddr + ARG_W'(blkLen);
        if (counted) blkCnt <= blkCnt - CNT_W'(1);
      end
      if (st.latchErr != '0) stickyErr <= stickyErr | st.latchErr;
      if (st.finish) begin
        counted <= 1'b0;
        relMode <= 1'b0;
      end
    end
  end

  // R2
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    counted |-> (blkCnt != '0));

  // R6
  rel_counted_chk: assert property (@(posedge clk) disable iff (!rstN)
    relMode |-> counted);

endmodule

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int CMD_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdIdx,
  input  logic             blkValid,
  input  logic             blkCrcOk,
  input  logic             cmdRangeBad,
  input  logic             cmdLenBad,
  input  logic             cmdMisBad,
  input  logic             blkRangeBad,
  input  logic             blkMisBad,
  input  logic             lastBlk,
  input  logic [3:0]       stickyErr,
  input  logic [ARG_W-1:0] curAddr,
  output strobe_t          st,
  output logic             rcvState,
  output logic             rspValid,
  output logic [4:0]       rspErr,
  output logic             progReq,
  output logic [ARG_W-1:0] progAddr
);

  wr_state_e  state, stNext;
  logic       rspVNext, progNext;
  logic [4:0] rspENext;

  always_comb begin
    st       = '0;
    stNext   = state;
    rspVNext = 1'b0;
    rspENext = '0;
    progNext = 1'b0;
    if (cmdValid) begin
      rspVNext = 1'b1;
      st.clr23 = (cmdIdx != CMD_SETCNT);
      case (cmdIdx)
        CMD_STOP: begin
          if (state == ST_RCV) begin
            rspENext  = {1'b0, stickyErr};
            st.finish = 1'b1;
            stNext    = ST_TRAN;
          end else begin
            rspENext[E_ILL] = 1'b1;
          end
        end
        CMD_SETCNT: st.ld23 = (state == ST_TRAN);
        CMD_WR1, CMD_WRN: begin
          if (state == ST_TRAN) begin
            rspENext[E_RANGE] = cmdRangeBad;
            rspENext[E_LEN]   = cmdLenBad;
            rspENext[E_MIS]   = cmdMisBad;
            if (!(cmdRangeBad || cmdLenBad || cmdMisBad)) begin
              st.start = 1'b1;
              st.multi = (cmdIdx == CMD_WRN);
              stNext   = ST_RCV;
            end
          end
        end
        default: ;
      endcase
    end else if (blkValid && (state == ST_RCV) && (stickyErr == '0)) begin
      if (!blkCrcOk)        st.latchErr[E_CRC]   = 1'b1;
      else if (blkRangeBad) st.latchErr[E_RANGE] = 1'b1;
      else if (blkMisBad)   st.latchErr[E_MIS]   = 1'b1;
      else begin
        st.advance = 1'b1;
        progNext   = 1'b1;
        if (lastBlk) begin
          st.finish = 1'b1;
          stNext    = ST_TRAN;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_TRAN;
      rspValid <= 1'b0;
      rspErr   <= '0;
      progReq  <= 1'b0;
      progAddr <= '0;
    end else begin
      state    <= stNext;
      rspValid <= rspVNext;
      rspErr   <= rspENext;
      progReq  <= progNext;
      if (progNext) progAddr <= curAddr;
    end
  end

  assign rcvState = (state == ST_RCV);

  // R13
  prog_in_rcv_chk: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> $past(state == ST_RCV));

  // R5
  illegal_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr[E_ILL]) |-> ($past(state == ST_TRAN) && (state == ST_TRAN)));

  // R8
  err_in_tran_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspErr != '0)) |-> (state == ST_TRAN));

endmodule

// File: rtl/blkwr_ctl.sv
module blkwr_ctl
  import blkwr_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 16,
  parameter int CMD_W       = 6,
  parameter int SECT_BYTES  = 512,
  parameter int MEM_BYTES   = 32'h0010_0000,
  parameter int REL_SECTORS = 8,
  parameter bit PARTIAL_OK  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdIdx,
  input  logic [ARG_W-1:0] cmdArg,
  input  logic [LEN_W-1:0] blkLen,
  input  logic             blkValid,
  input  logic             blkCrcOk,
  output logic             rcvState,
  output logic             relMode,
  output logic             rspValid,
  output logic [4:0]       rspErr,
  output logic             progReq,
  output logic [ARG_W-1:0] progAddr
);

  strobe_t          st;
  logic             cmdRangeBad, cmdLenBad, cmdMisBad;
  logic             blkRangeBad, blkMisBad, lastBlk;
  logic [3:0]       stickyErr;
  logic [ARG_W-1:0] curAddr;

  blkwr_ctrl #(.ARG_W(ARG_W), .CMD_W(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIdx(cmdIdx),
    .blkValid(blkValid), .blkCrcOk(blkCrcOk),
    .cmdRangeBad(cmdRangeBad), .cmdLenBad(cmdLenBad), .cmdMisBad(cmdMisBad),
    .blkRangeBad(blkRangeBad), .blkMisBad(blkMisBad), .lastBlk(lastBlk),
    .stickyErr(stickyErr), .curAddr(curAddr), .st(st),
    .rcvState(rcvState), .rspValid(rspValid), .rspErr(rspErr),
    .progReq(progReq), .progAddr(progAddr)
  );

  blkwr_dpath #(
    .ARG_W(ARG_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SECT_BYTES(SECT_BYTES),
    .MEM_BYTES(MEM_BYTES), .REL_SECTORS(REL_SECTORS), .PARTIAL_OK(PARTIAL_OK)
  ) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .cmdArg(cmdArg), .blkLen(blkLen),
    .cmdRangeBad(cmdRangeBad), .cmdLenBad(cmdLenBad), .cmdMisBad(cmdMisBad),
    .blkRangeBad(blkRangeBad), .blkMisBad(blkMisBad), .lastBlk(lastBlk),
    .relMode(relMode), .stickyErr(stickyErr), .curAddr(curAddr)
  );

endmodule

// File: tb/sim_blkwr_ctl.sv
module sim_blkwr_ctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [5:0]  cmdIdx = '0;
  logic [31:0] cmdArg = '0;
  logic [15:0] blkLen = 16'd512;
  logic        blkValid = 1'b0;
  logic        blkCrcOk = 1'b1;
  logic        rcvState, relMode, rspValid, progReq;
  logic [4:0]  rspErr;
  logic [31:0] progAddr;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blkwr_ctl u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIdx(cmdIdx), .cmdArg(cmdArg),
    .blkLen(blkLen), .blkValid(blkValid), .blkCrcOk(blkCrcOk),
    .rcvState(rcvState), .relMode(relMode), .rspValid(rspValid), .rspErr(rspErr),
    .progReq(progReq), .progAddr(progAddr)
  );

  typedef struct packed {
    logic        isBlk;
    logic [5:0]  code;
    logic [31:0] arg;
    logic [15:0] len;
    logic        crc;
    logic        eRcv;
    logic        eRspV;
    logic [4:0]  eErr;
    logic        eProg;
    logic [31:0] eAddr;
    logic        eRel;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 52;
  // fields: isBlk code arg len crc | eRcv eRspV eErr eProg eAddr eRel req
  localparam vec_t VEC [NV] = '{
    // R2: counted write of 2 blocks
    '{1'b0, 6'd23, 32'h2,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd2},
    '{1'b0, 6'd25, 32'h1000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd2},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h1000, 1'b0, 8'd13},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 32'h1200, 1'b0, 8'd2},
    // R5: stop after completion is illegal, block in transfer ignored
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h10, 1'b0, 32'h0,    1'b0, 8'd5},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b0, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd5},
    // R3: count separated by another command -> open-ended
    '{1'b0, 6'd23, 32'h3,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd3},
    '{1'b0, 6'd13, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd3},
    '{1'b0, 6'd25, 32'h2000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd3},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h2000, 1'b0, 8'd3},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h2200, 1'b0, 8'd3},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h2400, 1'b0, 8'd3},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h2600, 1'b0, 8'd13},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd3},
    // R4: zero count -> open-ended
    '{1'b0, 6'd23, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd4},
    '{1'b0, 6'd25, 32'h3000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd4},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h3000, 1'b0, 8'd4},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h3200, 1'b0, 8'd4},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd4},
    // R6: reliable granted (count 1 at 0x200, count 8 at 0x4000)
    '{1'b0, 6'd23, 32'h80000001, 16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd6},
    '{1'b0, 6'd25, 32'h200,      16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b1, 8'd6},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 32'h200,  1'b0, 8'd6},
    '{1'b0, 6'd23, 32'h80000008, 16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd6},
    '{1'b0, 6'd25, 32'h4000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b1, 8'd6},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd6},
    // R7: reliable denied (misaligned, then unsupported count)
    '{1'b0, 6'd23, 32'h80000008, 16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd7},
    '{1'b0, 6'd25, 32'h4200,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd7},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd7},
    '{1'b0, 6'd23, 32'h80000002, 16'd512, 1'b1, 1'b0, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd7},
    '{1'b0, 6'd25, 32'h0,        16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd7},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h0,    1'b0, 8'd7},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 32'h200,  1'b0, 8'd7},
    // R8, R9, R10: command-time rejection
    '{1'b0, 6'd25, 32'h100000,   16'd512, 1'b1, 1'b0, 1'b1, 5'h01, 1'b0, 32'h0,    1'b0, 8'd8},
    '{1'b0, 6'd24, 32'h1000,     16'd0,   1'b1, 1'b0, 1'b1, 5'h02, 1'b0, 32'h0,    1'b0, 8'd9},
    '{1'b0, 6'd24, 32'h1000,     16'd600, 1'b1, 1'b0, 1'b1, 5'h02, 1'b0, 32'h0,    1'b0, 8'd9},
    '{1'b0, 6'd24, 32'h1F0,      16'd32,  1'b1, 1'b0, 1'b1, 5'h04, 1'b0, 32'h0,    1'b0, 8'd10},
    // R2: single-block write ends by itself
    '{1'b0, 6'd24, 32'h5000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd2},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b0, 1'b0, 5'h00, 1'b1, 32'h5000, 1'b0, 8'd2},
    // R11: partial blocks drift across a boundary
    '{1'b0, 6'd25, 32'h6000,     16'd200, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd11},
    '{1'b1, 6'd0,  32'h0,        16'd200, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h6000, 1'b0, 8'd13},
    '{1'b1, 6'd0,  32'h0,        16'd200, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'h60C8, 1'b0, 8'd13},
    '{1'b1, 6'd0,  32'h0,        16'd200, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd11},
    '{1'b1, 6'd0,  32'h0,        16'd200, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd11},
    '{1'b0, 6'd12, 32'h0,        16'd200, 1'b1, 1'b0, 1'b1, 5'h04, 1'b0, 32'h0,    1'b0, 8'd11},
    // R12: CRC failure
    '{1'b0, 6'd25, 32'h7000,     16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd12},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b0, 1'b1, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd12},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd12},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h08, 1'b0, 32'h0,    1'b0, 8'd12},
    // R11: end of memory reached mid-stream
    '{1'b0, 6'd25, 32'hFFE00,    16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0,    1'b0, 8'd11},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b1, 32'hFFE00,1'b0, 8'd11},
    '{1'b1, 6'd0,  32'h0,        16'd512, 1'b1, 1'b1, 1'b0, 5'h00, 1'b0, 32'h0,    1'b0, 8'd11},
    '{1'b0, 6'd12, 32'h0,        16'd512, 1'b1, 1'b0, 1'b1, 5'h01, 1'b0, 32'h0,    1'b0, 8'd11}
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input int req);
    check(rcvState == 1'b0, req, "rcvState", 32'(rcvState), 32'h0);
    check(rspValid == 1'b0, req, "rspValid", 32'(rspValid), 32'h0);
    check(progReq == 1'b0, req, "progReq", 32'(progReq), 32'h0);
    check(relMode == 1'b0, req, "relMode", 32'(relMode), 32'h0);
  endtask

  task automatic runVec(input vec_t v);
    @(negedge clk);
    blkLen   = v.len;
    cmdIdx   = v.code;
    cmdArg   = v.arg;
    blkCrcOk = v.crc;
    cmdValid = !v.isBlk;
    blkValid = v.isBlk;
    @(negedge clk);
    cmdValid = 1'b0;
    blkValid = 1'b0;
    check(rcvState == v.eRcv, int'(v.req), "rcvState", 32'(rcvState), 32'(v.eRcv));
    check(rspValid == v.eRspV, int'(v.req), "rspValid", 32'(rspValid), 32'(v.eRspV));
    if (v.eRspV)
      check(rspErr == v.eErr, int'(v.req), "rspErr", 32'(rspErr), 32'(v.eErr));
    check(progReq == v.eProg, int'(v.req), "progReq", 32'(progReq), 32'(v.eProg));
    if (v.eProg)
      check(progAddr == v.eAddr, int'(v.req), "progAddr", progAddr, v.eAddr);
    check(relMode == v.eRel, int'(v.req), "relMode", 32'(relMode), 32'(v.eRel));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state out of reset
    checkIdle(1);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle(1);

    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R1: reset in the middle of an open-ended transfer
    runVec('{1'b0, 6'd25, 32'h8000, 16'd512, 1'b1, 1'b1, 1'b1, 5'h00, 1'b0, 32'h0, 1'b0, 8'd1});
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkIdle(1);
    // R5: stop right after reset is illegal
    runVec('{1'b0, 6'd12, 32'h0, 16'd512, 1'b1, 1'b0, 1'b1, 5'h10, 1'b0, 32'h0, 1'b0, 8'd5});

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL R1 watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule